// File: doc/BRIEF.md
# Four-Channel TDM Serial Port with Frame Hand-Off

This block connects a device to a shared 2048 kbit/s time-division serial stream that is clocked at 4.096 MHz. Each bit therefore occupies two clock periods. An active-low frame pulse marks the start of each frame. A frame has 32 timeslots of 8 bits, which is 512 clocks. The block owns the first four timeslots. In order these carry the D, C, B1 and B2 channels.

The receive side takes the four bytes off the input stream and presents them as one parallel word. The word is updated once per frame and a one-clock strobe marks the update. The transmit side takes four parallel bytes at the start of each frame and sends them serially in the matching timeslots. Outside those timeslots the output drive enable is released, so other devices can use the rest of the stream. The status byte in the C timeslot carries a half-frame flag. This flag is captured from an input while the frame pulse is low.

A one-clock, active-low hand-off pulse is raised where the block's timeslots end. A second device can use it as its own frame start. When frame pulses stop arriving, the frame counter keeps running and wraps every 512 clocks, so the timing stays regular.

Top module: `tdm_port`

## Requirements
- R1: During and right after synchronous reset: ser_oe=0, ser_dout=0, dly_frame_n=1, rx_valid=0, rx_bytes=0, half_flag=0, and the frame counter is at clock 0.
- R2: When frame_n is sampled low on a rising clock edge, the next clock is clock 0 of a new frame. Clock c of a frame belongs to timeslot c/16 and to bit (c/2)%8 of that timeslot, where bit 0 is sent first. A frame is 512 clocks.
- R3: In timeslots 0 to 3, ser_oe=1 and ser_dout carries byte k of the latched transmit word, MSB first. Byte k is tx_bytes[8k+7:8k], with k=0 for D, 1 for C, 2 for B1 and 3 for B2. Each bit is held for both clocks of its cell.
- R4: In timeslots 4 to 31, ser_oe=0 and ser_dout=0.
- R5: tx_bytes is latched on the edge that starts a frame. Changes to tx_bytes during a frame do not affect the bits sent in that frame.
- R6: ser_din is sampled on the rising edge that ends the first clock of each bit cell in timeslots 0 to 3. Each slot's bits are assembled MSB first. On the edge that samples the last bit of timeslot 3, all four bytes are written to rx_bytes at once, using the R3 byte positions. rx_valid is 1 for exactly that following clock (clock 63). Data in other timeslots never changes rx_bytes.
- R7: dly_frame_n is 0 for exactly one clock, clock 64, which is the first clock of timeslot 4. It is 1 on all other clocks.
- R8: half_in is captured only on edges where frame_n is low, and it appears on half_flag from the next clock. Bit 0 (the LSB, sent last) of the C timeslot byte carries this flag in place of tx_bytes[8].
- R9: Without a frame pulse, the counter wraps from clock 511 to clock 0. This starts a new frame that re-latches tx_bytes and keeps the output schedule.
- R10: A frame pulse that arrives part-way through a frame restarts the frame at clock 0 at once. A frame cut short before clock 63 produces no rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame start pulse |
| half_in | input | 1 | Half-frame select, captured while frame_n is low |
| ser_din | input | 1 | Serial input stream |
| tx_bytes | input | 32 | Transmit bytes, D in [7:0], C in [15:8], B1 in [23:16], B2 in [31:24] |
| ser_dout | output | 1 | Serial output data, 0 when not driving |
| ser_oe | output | 1 | Output drive enable for the stream pad |
| dly_frame_n | output | 1 | Active-low hand-off pulse for the next device |
| rx_bytes | output | 32 | Received bytes, same layout as tx_bytes |
| rx_valid | output | 1 | One-clock strobe when rx_bytes updates |
| half_flag | output | 1 | Latched half-frame flag |

## Verification
The hardest situations to reach are frames that do not last 512 clocks. One case is a pulse that cuts a frame short, possibly before the receive strobe. The other is a long gap in which the counter must wrap by itself and latch the transmit word again. The stimulus covers these with several phases. One phase runs over 1300 clocks with no pulse. Another places pulses at 300, 100, 37 and 700 clock spacings. Throughout, half_in and tx_bytes are changed at random on clocks with no pulse and in the middle of frames, so the capture windows are tested against data that changes.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int DEF_SLOTS         = 32;
  localparam int DEF_SLOT_BITS     = 8;
  localparam int DEF_CH            = 4;
  localparam int DEF_CLKS_PER_BIT  = 2;
  localparam int DEF_STAT_CH       = 1;
  localparam int DEF_HALF_BIT      = 0;

  function automatic int frame_clks(int slots, int bits, int cpb);
    return slots * bits * cpb;
  endfunction

  function automatic int owned_clks(int ch, int bits, int cpb);
    return ch * bits * cpb;
  endfunction
endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase
  import tdm_pkg::*;
#(
  parameter int NUM_SLOTS    = DEF_SLOTS,
  parameter int SLOT_BITS    = DEF_SLOT_BITS,
  parameter int NUM_CH       = DEF_CH,
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  parameter int CNT_W        = $clog2(frame_clks(NUM_SLOTS, SLOT_BITS, CLKS_PER_BIT))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             half_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             frame_start,
  output logic             half_q,
  output logic             half_nxt,
  output logic             dly_frame_n
);
  localparam int FRAME_LEN = frame_clks(NUM_SLOTS, SLOT_BITS, CLKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST_CLK = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] HAND_OFF = CNT_W'(owned_clks(NUM_CH, SLOT_BITS, CLKS_PER_BIT));

  logic fp_low;

  always_comb begin
    fp_low = !frame_n;
    if (fp_low) begin
      cnt_nxt = '0;
    end else if (cnt_q == LAST_CLK) begin
      cnt_nxt = '0;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
    end
    frame_start = (cnt_nxt == '0);
    half_nxt    = fp_low ? half_in : half_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      half_q      <= 1'b0;
      dly_frame_n <= 1'b1;
    end else begin
      cnt_q       <= cnt_nxt;
      half_q      <= half_nxt;
      dly_frame_n <= (cnt_nxt != HAND_OFF);
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_pkg::*;
#(
  parameter int NUM_SLOTS    = DEF_SLOTS,
  parameter int SLOT_BITS    = DEF_SLOT_BITS,
  parameter int NUM_CH       = DEF_CH,
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  parameter int CNT_W        = $clog2(frame_clks(NUM_SLOTS, SLOT_BITS, CLKS_PER_BIT))
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            cnt_q,
  input  logic                        ser_din,
  output logic [NUM_CH*SLOT_BITS-1:0] rx_bytes,
  output logic                        rx_valid
);
  localparam int PH_W   = $clog2(CLKS_PER_BIT);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int SLOT_W = CNT_W - PH_W - BIT_W;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam logic [PH_W-1:0]   SAMPLE_PH = PH_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] OWN_END   = SLOT_W'(NUM_CH);
  localparam logic [SLOT_W-1:0] LAST_CH   = SLOT_W'(NUM_CH - 1);

  logic [PH_W-1:0]      phase_c;
  logic [BIT_W-1:0]     bit_c;
  logic [SLOT_W-1:0]    slot_c;
  logic                 sample_en;
  logic                 byte_done;
  logic [SLOT_BITS-1:0] shift_q;
  logic [SLOT_BITS-1:0] shift_nxt;
  logic [SLOT_BITS-1:0] stage_q [NUM_CH];
  logic [NUM_CH*SLOT_BITS-1:0] word_q;
  logic                 valid_q;

  always_comb begin
    phase_c   = cnt_q[PH_W-1:0];
    bit_c     = cnt_q[PH_W +: BIT_W];
    slot_c    = cnt_q[CNT_W-1 -: SLOT_W];
    sample_en = (phase_c == SAMPLE_PH) && (slot_c < OWN_END);
    byte_done = sample_en && (bit_c == LAST_BIT);
    shift_nxt = {shift_q[SLOT_BITS-2:0], ser_din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      for (int k = 0; k < NUM_CH; k++) stage_q[k] <= '0;
    end else if (sample_en) begin
      shift_q <= shift_nxt;
      if (byte_done) stage_q[slot_c[CH_W-1:0]] <= shift_nxt;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q[g*SLOT_BITS +: SLOT_BITS] <= '0;
        end else if (byte_done && (slot_c == LAST_CH)) begin
          if (g == NUM_CH - 1) begin
            word_q[g*SLOT_BITS +: SLOT_BITS] <= shift_nxt;
          end else begin
            word_q[g*SLOT_BITS +: SLOT_BITS] <= stage_q[g];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= byte_done && (slot_c == LAST_CH);
    end
  end

  assign rx_bytes = word_q;
  assign rx_valid = valid_q;
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_pkg::*;
#(
  parameter int NUM_SLOTS    = DEF_SLOTS,
  parameter int SLOT_BITS    = DEF_SLOT_BITS,
  parameter int NUM_CH       = DEF_CH,
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  parameter int STAT_CH      = DEF_STAT_CH,
  parameter int HALF_BIT     = DEF_HALF_BIT,
  parameter int CNT_W        = $clog2(frame_clks(NUM_SLOTS, SLOT_BITS, CLKS_PER_BIT))
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            cnt_nxt,
  input  logic                        frame_start,
  input  logic                        half_nxt,
  input  logic [NUM_CH*SLOT_BITS-1:0] tx_bytes,
  output logic                        ser_dout,
  output logic                        ser_oe
);
  localparam int PH_W   = $clog2(CLKS_PER_BIT);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int SLOT_W = CNT_W - PH_W - BIT_W;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam logic [SLOT_W-1:0] OWN_END   = SLOT_W'(NUM_CH);
  localparam logic [SLOT_W-1:0] STAT_SLOT = SLOT_W'(STAT_CH);
  localparam logic [BIT_W-1:0]  MSB_IDX   = BIT_W'(SLOT_BITS - 1);

  logic [NUM_CH*SLOT_BITS-1:0] hold_q;
  logic [NUM_CH*SLOT_BITS-1:0] src_word;
  logic [SLOT_W-1:0]           slot_n;
  logic [BIT_W-1:0]            bit_n;
  logic [BIT_W-1:0]            bit_idx;
  logic [SLOT_BITS-1:0]        cur_byte;
  logic                        own_n;
  logic                        dout_q;
  logic                        oe_q;

  always_comb begin
    src_word = frame_start ? tx_bytes : hold_q;
    slot_n   = cnt_nxt[CNT_W-1 -: SLOT_W];
    bit_n    = cnt_nxt[PH_W +: BIT_W];
    bit_idx  = MSB_IDX - bit_n;
    own_n    = (slot_n < OWN_END);
    cur_byte = src_word[slot_n[CH_W-1:0]*SLOT_BITS +: SLOT_BITS];
    if (slot_n == STAT_SLOT) cur_byte[HALF_BIT] = half_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (frame_start) hold_q <= tx_bytes;
      dout_q <= own_n & cur_byte[bit_idx];
      oe_q   <= own_n;
    end
  end

  assign ser_dout = dout_q;
  assign ser_oe   = oe_q;
endmodule

// File: rtl/tdm_port.sv
module tdm_port
  import tdm_pkg::*;
#(
  parameter int NUM_SLOTS    = DEF_SLOTS,
  parameter int SLOT_BITS    = DEF_SLOT_BITS,
  parameter int NUM_CH       = DEF_CH,
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  parameter int STAT_CH      = DEF_STAT_CH,
  parameter int HALF_BIT     = DEF_HALF_BIT
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_n,
  input  logic                        half_in,
  input  logic                        ser_din,
  input  logic [NUM_CH*SLOT_BITS-1:0] tx_bytes,
  output logic                        ser_dout,
  output logic                        ser_oe,
  output logic                        dly_frame_n,
  output logic [NUM_CH*SLOT_BITS-1:0] rx_bytes,
  output logic                        rx_valid,
  output logic                        half_flag
);
  localparam int CNT_W = $clog2(frame_clks(NUM_SLOTS, SLOT_BITS, CLKS_PER_BIT));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             frame_start;
  logic             half_q;
  logic             half_nxt;

  tdm_timebase #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .NUM_CH(NUM_CH),
    .CLKS_PER_BIT(CLKS_PER_BIT), .CNT_W(CNT_W)
  ) tb_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .half_in(half_in),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .frame_start(frame_start),
    .half_q(half_q), .half_nxt(half_nxt), .dly_frame_n(dly_frame_n)
  );

  tdm_rx_deser #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .NUM_CH(NUM_CH),
    .CLKS_PER_BIT(CLKS_PER_BIT), .CNT_W(CNT_W)
  ) rx_i (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .ser_din(ser_din),
    .rx_bytes(rx_bytes), .rx_valid(rx_valid)
  );

  tdm_tx_ser #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .NUM_CH(NUM_CH),
    .CLKS_PER_BIT(CLKS_PER_BIT), .STAT_CH(STAT_CH), .HALF_BIT(HALF_BIT),
    .CNT_W(CNT_W)
  ) tx_i (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .frame_start(frame_start),
    .half_nxt(half_nxt), .tx_bytes(tx_bytes),
    .ser_dout(ser_dout), .ser_oe(ser_oe)
  );

  assign half_flag = half_q;
endmodule

// File: rtl/tdm_port_chk.sv
module tdm_port_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_n,
  input logic              half_in,
  input logic              ser_dout,
  input logic              ser_oe,
  input logic              dly_frame_n,
  input logic [WORD_W-1:0] rx_bytes,
  input logic              rx_valid,
  input logic              half_flag
);
  // R4: released output carries no data
  p_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> !ser_dout);

  // R7: hand-off pulse lasts one clock
  p_handoff_one_r7: assert property (@(posedge clk) disable iff (rst)
    !dly_frame_n |=> dly_frame_n);

  // R7 with R4: hand-off follows the last owned clock and the drive is released then
  p_handoff_edge_r7: assert property (@(posedge clk) disable iff (rst)
    !dly_frame_n |-> (!ser_oe && $past(ser_oe)));

  // R2 with R3: a frame pulse starts slot 0, which is driven
  p_start_drive_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> ser_oe);

  // R8: flag follows half_in seen during the pulse
  p_half_capture_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> (half_flag == $past(half_in)));

  // R8: flag only moves after a pulse
  p_half_hold_r8: assert property (@(posedge clk) disable iff (rst)
    frame_n |=> $stable(half_flag));

  // R6: strobe is single-clock
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6: received word changes only alongside the strobe, inside the owned slots
  p_word_update_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_bytes) |-> (rx_valid && ser_oe));
endmodule

bind tdm_port tdm_port_chk #(.WORD_W(NUM_CH*SLOT_BITS)) chk_i (
  .clk(clk), .rst(rst), .frame_n(frame_n), .half_in(half_in),
  .ser_dout(ser_dout), .ser_oe(ser_oe), .dly_frame_n(dly_frame_n),
  .rx_bytes(rx_bytes), .rx_valid(rx_valid), .half_flag(half_flag)
);

// File: tb/tdm_port_tb_top.sv
module tdm_port_tb_top;
  localparam int FR = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        frame_n;
  logic        half_in;
  logic        ser_din;
  logic [31:0] tx_bytes;
  logic        ser_dout;
  logic        ser_oe;
  logic        dly_frame_n;
  logic [31:0] rx_bytes;
  logic        rx_valid;
  logic        half_flag;

  tdm_port dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .half_in(half_in),
    .ser_din(ser_din), .tx_bytes(tx_bytes), .ser_dout(ser_dout),
    .ser_oe(ser_oe), .dly_frame_n(dly_frame_n), .rx_bytes(rx_bytes),
    .rx_valid(rx_valid), .half_flag(half_flag)
  );

  int    errors = 0;
  int    checks = 0;
  string ph = "R1";
  bit    comparing = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h", req, ph, $time, act, exp);
    end
  endtask

  // behavioural reference state
  int          m_cnt;
  int          m_nxt;
  int          m_s;
  int          m_b;
  logic [31:0] m_txh;
  logic        m_half;
  logic [7:0]  m_sh;
  logic [7:0]  m_stage [3];
  logic [7:0]  m_byte;
  logic [31:0] e_rx;
  logic        e_valid;
  logic        e_dout;
  logic        e_oe;
  logic        e_dfp;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_txh = '0; m_half = 1'b0; m_sh = '0;
      for (int i = 0; i < 3; i++) m_stage[i] = '0;
      e_rx = '0; e_valid = 1'b0; e_dout = 1'b0; e_oe = 1'b0; e_dfp = 1'b1;
    end else begin
      e_valid = 1'b0;
      m_s = m_cnt / 16;
      m_b = (m_cnt / 2) % 8;
      if ((m_cnt % 2 == 0) && (m_s < 4)) begin
        m_sh = {m_sh[6:0], ser_din};
        if (m_b == 7) begin
          if (m_s < 3) m_stage[m_s] = m_sh;
          else begin
            e_rx = {m_sh, m_stage[2], m_stage[1], m_stage[0]};
            e_valid = 1'b1;
          end
        end
      end
      m_nxt = (!frame_n) ? 0 : (m_cnt + 1) % FR;
      if (!frame_n) m_half = half_in;
      if (m_nxt == 0) m_txh = tx_bytes;
      m_s = m_nxt / 16;
      m_b = (m_nxt / 2) % 8;
      if (m_s < 4) begin
        m_byte = m_txh[8*m_s +: 8];
        if (m_s == 1) m_byte[0] = m_half;
        e_oe = 1'b1;
        e_dout = m_byte[7 - m_b];
      end else begin
        e_oe = 1'b0;
        e_dout = 1'b0;
      end
      e_dfp = (m_nxt != 64);
      m_cnt = m_nxt;
    end
  end

  always @(negedge clk) begin
    if (comparing && !rst) begin
      chk(e_oe ? "R3" : "R4", {31'd0, ser_dout}, {31'd0, e_dout});
      chk(e_oe ? "R3" : "R4", {31'd0, ser_oe}, {31'd0, e_oe});
      chk("R7", {31'd0, dly_frame_n}, {31'd0, e_dfp});
      chk("R6", rx_bytes, e_rx);
      chk("R6", {31'd0, rx_valid}, {31'd0, e_valid});
      chk("R8", {31'd0, half_flag}, {31'd0, m_half});
    end
  end

  task automatic step(bit pulse);
    @(negedge clk);
    frame_n = !pulse;
    ser_din = 1'($urandom);
    half_in = 1'($urandom);
    if (($urandom % 40) == 0) tx_bytes = $urandom;
  endtask

  task automatic frames(int len, int count);
    for (int f = 0; f < count; f++) begin
      step(1'b1);
      for (int c = 1; c < len; c++) step(1'b0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; frame_n = 1'b1; half_in = 1'b0; ser_din = 1'b0;
    tx_bytes = 32'hA5C3_3C5A;
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1", {31'd0, ser_oe}, 32'd0);
    chk("R1", {31'd0, ser_dout}, 32'd0);
    chk("R1", {31'd0, dly_frame_n}, 32'd1);
    chk("R1", {31'd0, rx_valid}, 32'd0);
    chk("R1", rx_bytes, 32'd0);
    chk("R1", {31'd0, half_flag}, 32'd0);
    rst = 1'b0;
    comparing = 1'b1;
    ph = "R2";
    frames(FR, 3);
    ph = "R9";
    for (int c = 0; c < 1300; c++) step(1'b0);
    ph = "R10";
    frames(300, 1);
    frames(100, 1);
    frames(37, 1);
    frames(700, 1);
    ph = "R5";
    frames(FR, 2);
    ph = "R8";
    frames(FR, 2);
    step(1'b0);
    step(1'b0);
    finish_run();
  end
endmodule